// File: doc/BRIEF.md
# Configuration Length-Count Completion Controller

This block decides when a serial configuration load has finished. A free-running completion counter advances on every configuration clock. It starts with the first clock after reset and does not wait for any preamble. A length register is written by a one-cycle strobe. Completion is declared only in a cycle where three things hold together: the length register has been written, the frame memory reports full, and the counter equals the stored length exactly.

If the memory is not yet full when the counter passes the length, nothing is lost but time. The counter runs on through its terminal value, wraps to zero, and completes on its next exact match. A single stray leading clock therefore delays completion by one full counter period.

Completion starts a short startup sequence. The sequence raises DONE, then enables the user outputs, then releases the global reset, and each step takes one startup tick. The startup ticks come either from the configuration clock or from an external tick strobe. An optional frame-check path pulls the active-low INIT output low when an error is flagged during loading. Both the tick source and the frame-check enable are straps captured while reset is held.

Top module: `cfg_done_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, `done_o`=0, `oe_o`=0, `gsr_o`=1 and `init_n_o`=1.
- R2: The counter (width `CNT_W`, default 24) is 0 in reset and holds N after N clock edges with reset released. When `mem_full`=1 at the edge where the count equals the stored length, `done_o` is 1 after that edge. With the length loaded at edge 1, a length L gives `done_o`=1 from edge L+1 onward.
- R3: Before any `len_ld` pulse, no count value causes completion, even with `mem_full`=1 through a counter wrap. A `len_ld` pulse stores `len_val` at the edge where it is sampled.
- R4: If `mem_full`=0 when the count equals the length, the counter wraps modulo 2^`CNT_W` and completion happens at the next exact match. Memory that becomes full one count late therefore delays `done_o` by 2^`CNT_W` edges.
- R5: Once `done_o` is 1, the counter stops. `done_o`, `oe_o` and the released `gsr_o` then hold until reset, whatever `mem_full` and `len_ld` do.
- R6: With the frame check strapped on, a `crc_err`=1 sampled before completion drives `init_n_o` to 0 from the next edge until reset. This includes an error sampled at the very edge where completion is recorded. An error sampled after completion has no effect.
- R7: With the frame check strapped off, `crc_err` never affects `init_n_o`.
- R8: The startup sequence enters phase 0 at completion and advances by one phase per startup tick, stopping at phase `N_PH`-1. In the default order, `done_o` rises in phase 0, `oe_o` rises in phase 1 and `gsr_o` falls in phase 2.
- R9: With `cfg_user_clk`=0 at reset, every clock edge is a startup tick. With `cfg_user_clk`=1 at reset, only edges that sample `user_tick`=1 are ticks.
- R10: `cfg_crc_on` and `cfg_user_clk` are sampled only while reset is held. Changing them afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset / program request |
| len_ld | input | 1 | One-cycle strobe that writes the length register |
| len_val | input | CNT_W | Length value stored on `len_ld` |
| mem_full | input | 1 | Frame memory full flag |
| crc_err | input | 1 | Frame check error flag |
| cfg_crc_on | input | 1 | Strap: enable frame check (sampled in reset) |
| cfg_user_clk | input | 1 | Strap: startup ticks from `user_tick` (sampled in reset) |
| user_tick | input | 1 | External startup tick strobe |
| done_o | output | 1 | Configuration done |
| init_n_o | output | 1 | Active-low frame error indicator |
| oe_o | output | 1 | User outputs enabled |
| gsr_o | output | 1 | Global reset held (1) or released (0) |

## Verification
Two functions can fall on the same edge: a frame error and the exact count match that records completion. The bench raises `crc_err` only during the cycle before the completing edge. It then expects both `done_o`=1 and `init_n_o`=0 after that edge. In a second run it raises the error one cycle later and expects `init_n_o` to stay 1. A behavioural model keeps integer count, length and phase state, updates them on every edge, and its outputs are compared with the design's outputs on every clock.

// File: rtl/cfg_done_pkg.sv
package cfg_done_pkg;

   // straps captured while reset is held
   typedef struct packed {
      logic crc_on;
      logic user_src;
   } strap_t;

   function automatic int ph_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/cfg_len_match.sv
module cfg_len_match #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             len_ld,
   input  logic [CNT_W-1:0] len_val,
   input  logic             mem_full,
   input  logic             frz,
   output logic             hit
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_q;
   logic             len_vld_q;

   initial begin : elab_chk
      assert (CNT_W >= 2) else $fatal(1, "CNT_W must be at least 2");
   end

   // counter runs from the first clock, never gated by data alignment
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!frz) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q     <= '0;
         len_vld_q <= 1'b0;
      end else if (len_ld) begin
         len_q     <= len_val;
         len_vld_q <= 1'b1;
      end
   end

   assign hit = len_vld_q && mem_full && (cnt_q == len_q);

   // R2 R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frz |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R5
   cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frz |=> $stable(cnt_q));

   // R3
   len_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len_vld_q && !len_ld) |=> (len_vld_q && $stable(len_q)));

endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq #(
   parameter int N_PH    = 3,
   parameter int DONE_PH = 0,
   parameter int OE_PH   = 1,
   parameter int GSR_PH  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic tick,
   output logic act_o,
   output logic done_o,
   output logic oe_o,
   output logic gsr_o
);

   localparam int              PH_W    = cfg_done_pkg::ph_bits(N_PH);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(N_PH - 1);

   logic            act_q;
   logic [PH_W-1:0] ph_q;

   initial begin : elab_chk
      assert (N_PH >= 1) else $fatal(1, "N_PH must be positive");
      assert (DONE_PH >= 0 && DONE_PH < N_PH) else $fatal(1, "DONE_PH out of range");
      assert (OE_PH   >= 0 && OE_PH   < N_PH) else $fatal(1, "OE_PH out of range");
      assert (GSR_PH  >= 0 && GSR_PH  < N_PH) else $fatal(1, "GSR_PH out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         ph_q  <= '0;
      end else if (!act_q) begin
         if (go) begin
            act_q <= 1'b1;
            ph_q  <= '0;
         end
      end else if (tick && (ph_q != PH_LAST)) begin
         ph_q <= ph_q + 1'b1;
      end
   end

   assign act_o  = act_q;
   assign done_o = act_q && (int'(ph_q) >= DONE_PH);
   assign oe_o   = act_q && (int'(ph_q) >= OE_PH);
   assign gsr_o  = !(act_q && (int'(ph_q) >= GSR_PH));

   // R8
   enter_ph0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_q) |-> (ph_q == '0));

   // R8
   ph_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_q |=> ((ph_q == $past(ph_q)) || (ph_q == $past(ph_q) + 1'b1)));

   // R9
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !tick) |=> $stable(ph_q));

   // R5
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_q |=> act_q);

endmodule

// File: rtl/cfg_crc_flag.sv
module cfg_crc_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic crc_on,
   input  logic crc_err,
   input  logic busy,
   output logic init_n_o
);

   logic err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (crc_on && crc_err && busy) begin
         err_q <= 1'b1;
      end
   end

   assign init_n_o = !err_q;

   // R6
   init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !init_n_o |=> !init_n_o);

   // R7
   crc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !crc_on |-> init_n_o);

endmodule

// File: rtl/cfg_done_ctrl.sv
module cfg_done_ctrl #(
   parameter int CNT_W   = 24,
   parameter int N_PH    = 3,
   parameter int DONE_PH = 0,
   parameter int OE_PH   = 1,
   parameter int GSR_PH  = 2,
   parameter bit HAS_CRC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             len_ld,
   input  logic [CNT_W-1:0] len_val,
   input  logic             mem_full,
   input  logic             crc_err,
   input  logic             cfg_crc_on,
   input  logic             cfg_user_clk,
   input  logic             user_tick,
   output logic             done_o,
   output logic             init_n_o,
   output logic             oe_o,
   output logic             gsr_o
);

   cfg_done_pkg::strap_t strap_q;
   logic                 hit;
   logic                 seq_act;
   logic                 st_tick;

   // straps follow the pins only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strap_q.crc_on   <= cfg_crc_on;
         strap_q.user_src <= cfg_user_clk;
      end
   end

   assign st_tick = strap_q.user_src ? user_tick : 1'b1;

   cfg_len_match #(
      .CNT_W (CNT_W)
   ) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .len_ld   (len_ld),
      .len_val  (len_val),
      .mem_full (mem_full),
      .frz      (seq_act),
      .hit      (hit)
   );

   cfg_startup_seq #(
      .N_PH    (N_PH),
      .DONE_PH (DONE_PH),
      .OE_PH   (OE_PH),
      .GSR_PH  (GSR_PH)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (hit),
      .tick   (st_tick),
      .act_o  (seq_act),
      .done_o (done_o),
      .oe_o   (oe_o),
      .gsr_o  (gsr_o)
   );

   generate
      if (HAS_CRC) begin : g_crc
         cfg_crc_flag u_crc (
            .clk      (clk),
            .rst_n    (rst_n),
            .crc_on   (strap_q.crc_on),
            .crc_err  (crc_err),
            .busy     (!seq_act),
            .init_n_o (init_n_o)
         );
      end else begin : g_no_crc
         logic unused_crc;
         assign unused_crc = crc_err ^ strap_q.crc_on;
         assign init_n_o   = 1'b1;
      end
   endgenerate

   // R2
   done_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_act) |-> $past(mem_full));

   // R10
   strap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(strap_q));

endmodule

// File: tb/cfg_done_ctrl_bench.sv
module cfg_done_ctrl_bench;

   localparam int W = 8;
   localparam int M = 256;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         len_ld = 1'b0;
   logic [W-1:0] len_val = '0;
   logic         mem_full = 1'b0;
   logic         crc_err = 1'b0;
   logic         cfg_crc_on = 1'b0;
   logic         cfg_user_clk = 1'b0;
   logic         user_tick = 1'b0;
   logic         done_o, init_n_o, oe_o, gsr_o;

   int n_chk = 0;
   int n_fail = 0;
   bit seen_edge = 1'b0;
   bit finished = 1'b0;

   // behavioural reference state
   int m_cnt = 0, m_len = 0, m_ph = 0;
   bit m_lv = 0, m_act = 0, m_err = 0, m_crc = 0, m_usr = 0;

   always #5 clk = ~clk;

   cfg_done_ctrl #(.CNT_W(W)) u_cfg_done_ctrl (
      .clk(clk), .rst_n(rst_n), .len_ld(len_ld), .len_val(len_val),
      .mem_full(mem_full), .crc_err(crc_err), .cfg_crc_on(cfg_crc_on),
      .cfg_user_clk(cfg_user_clk), .user_tick(user_tick),
      .done_o(done_o), .init_n_o(init_n_o), .oe_o(oe_o), .gsr_o(gsr_o));

   always @(posedge clk) begin
      bit hit, tk, old_act;
      seen_edge = 1'b1;
      if (!rst_n) begin
         m_cnt = 0; m_len = 0; m_lv = 0; m_act = 0; m_ph = 0; m_err = 0;
         m_crc = cfg_crc_on; m_usr = cfg_user_clk;
      end else begin
         old_act = m_act;
         hit = m_lv && (m_cnt == m_len) && mem_full;
         tk = m_usr ? user_tick : 1'b1;
         if (!old_act && m_crc && crc_err) m_err = 1;
         if (len_ld) begin m_len = len_val; m_lv = 1; end
         if (old_act) begin
            if (tk && m_ph < 2) m_ph++;
         end else if (hit) begin
            m_act = 1; m_ph = 0;
         end
         if (!old_act) m_cnt = (m_cnt + 1) % M;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model (R1 R2 R5 R6 R8)
   always @(negedge clk) begin
      if (seen_edge && !finished) begin
         chk(done_o === m_act, "R2 model done_o", done_o, m_act);
         chk(oe_o === (m_act && m_ph >= 1), "R8 model oe_o", oe_o, m_act && m_ph >= 1);
         chk(gsr_o === !(m_act && m_ph >= 2), "R8 model gsr_o", gsr_o, !(m_act && m_ph >= 2));
         chk(init_n_o === !m_err, "R6 model init_n_o", init_n_o, !m_err);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic do_reset(input bit crc, input bit usr);
      @(negedge clk);
      rst_n = 0; cfg_crc_on = crc; cfg_user_clk = usr;
      len_ld = 0; len_val = '0; mem_full = 0; crc_err = 0; user_tick = 0;
      step(3);
      chk(done_o === 0 && oe_o === 0 && gsr_o === 1 && init_n_o === 1,
          "R1 reset outputs", {done_o, oe_o, gsr_o, init_n_o}, 4'b0011);
      rst_n = 1;
   endtask

   task automatic load(input int l);
      len_ld = 1; len_val = W'(l);
      step(1);
      len_ld = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // exact length, default order (R2 R8 R5)
      do_reset(0, 0);
      mem_full = 1;
      chk(done_o === 0, "R1 first cycle done_o", done_o, 0);
      load(20);
      step(19);
      chk(done_o === 0, "R2 done before match", done_o, 0);
      step(1);
      chk(done_o === 1, "R2 done at L+1", done_o, 1);
      chk(oe_o === 0 && gsr_o === 1, "R8 phase0", {oe_o, gsr_o}, 2'b01);
      step(1);
      chk(oe_o === 1 && gsr_o === 1, "R8 phase1", {oe_o, gsr_o}, 2'b11);
      step(1);
      chk(gsr_o === 0, "R8 phase2 gsr_o", gsr_o, 0);
      mem_full = 0;
      load(5);
      step(30);
      chk(done_o === 1 && oe_o === 1 && gsr_o === 0, "R5 hold", {done_o, oe_o, gsr_o}, 3'b110);

      // one clock late: wrap to completion (R4)
      do_reset(0, 0);
      load(20);
      step(20);
      mem_full = 1;
      chk(done_o === 0, "R4 missed match", done_o, 0);
      step(255);
      chk(done_o === 0, "R4 before wrap match", done_o, 0);
      step(1);
      chk(done_o === 1, "R4 done after wrap", done_o, 1);

      // unloaded length ignored (R3)
      do_reset(0, 0);
      mem_full = 1;
      step(300);
      chk(done_o === 0, "R3 no length no done", done_o, 0);
      load(50);
      step(5);
      chk(done_o === 0, "R3 before match", done_o, 0);
      step(1);
      chk(done_o === 1, "R3 done after load", done_o, 1);

      // frame error early (R6)
      do_reset(1, 0);
      mem_full = 1;
      load(20);
      step(3);
      crc_err = 1; step(1); crc_err = 0;
      chk(init_n_o === 0, "R6 init low", init_n_o, 0);
      step(16);
      chk(done_o === 1 && init_n_o === 0, "R6 init low kept", {done_o, init_n_o}, 2'b10);

      // error and match on the same edge (R6)
      do_reset(1, 0);
      mem_full = 1;
      load(20);
      step(19);
      crc_err = 1; step(1); crc_err = 0;
      chk(done_o === 1 && init_n_o === 0, "R6 same edge", {done_o, init_n_o}, 2'b10);

      // error one edge after completion (R6)
      do_reset(1, 0);
      mem_full = 1;
      load(20);
      step(20);
      crc_err = 1; step(1); crc_err = 0;
      chk(done_o === 1 && init_n_o === 1, "R6 after done ignored", {done_o, init_n_o}, 2'b11);

      // check disabled, strap changed after reset (R7 R10)
      do_reset(0, 0);
      cfg_crc_on = 1;
      crc_err = 1; step(10); crc_err = 0;
      chk(init_n_o === 1, "R7 R10 crc off", init_n_o, 1);

      // external startup ticks (R9 R10)
      do_reset(0, 1);
      cfg_user_clk = 0;
      mem_full = 1;
      load(10);
      step(10);
      chk(done_o === 1 && oe_o === 0, "R9 phase0 waits", {done_o, oe_o}, 2'b10);
      step(4);
      chk(oe_o === 0, "R9 R10 no tick no step", oe_o, 0);
      user_tick = 1; step(1); user_tick = 0;
      chk(oe_o === 1 && gsr_o === 1, "R9 first tick", {oe_o, gsr_o}, 2'b11);
      step(3);
      chk(gsr_o === 1, "R9 gsr held", gsr_o, 1);
      user_tick = 1; step(1); user_tick = 0;
      chk(gsr_o === 0, "R9 second tick", gsr_o, 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule